// File: doc/BRIEF.md
# Chained FIFO Ownership Controller

This controller sits beside the pointers of one FIFO device and lets several identical devices be strung together into one deeper buffer. Write ownership and read ownership are tokens. Exactly one device in a chain holds each token, and only the holder may accept writes or deliver reads. When the holder touches its last physical location on a granted access, it gives up the token. It then emits a one-cycle pulse that hands the token to the next device. The write token moves in the write clock domain and the read token moves in the read clock domain.

The same block works out whether the device runs alone (or side by side for width) or as a link in a depth chain. A strap marks the device that starts with both tokens. A device is standalone when its strap and both expansion inputs are low during reset; otherwise it is a chain link. Detection relies on a presence level: during reset, every strap-high device drives both expansion outputs high. That level reaches the following device even when the following device is the strapped first link of a ring. In standalone mode the shared output pin carries the local half-full flag, the ownership gates stay open and no pulses are emitted. The FIFO storage and the flag logic lie outside this block.

Top module: `chain_token_ctrl`

## Requirements
- R1: The mode is captured on every clock edge while rst_n is low. It is standalone when first_dev, and the expansion input of that clock domain, are both low; otherwise it is chain mode. After reset the mode does not change.
- R2: In standalone mode:
  - wr_xout_hf equals half_full at all times outside reset.
  - wr_allow and rd_allow are held high.
  - rd_xout stays low.
  - An access on the last location releases nothing.
- R3: While rst_n is low, wr_xout_hf and rd_xout both equal first_dev.
- R4: After reset in chain mode, a device with first_dev low has wr_allow and rd_allow high. A device with first_dev high has both low.
- R5: A write edge with wr_en, wr_allow and wr_last all high (chain mode) makes wr_allow low after that edge. It also makes wr_xout_hf high for exactly the one following write-clock cycle.
- R6: A read edge with rd_en, rd_allow and rd_last all high (chain mode) makes rd_allow low after that edge. It also makes rd_xout high for exactly the one following read-clock cycle.
- R7: In chain mode, a high level on wr_xin (rd_xin) at a clock edge makes wr_allow (rd_allow) high after that edge.
- R8: A granted access with the last-location input low keeps the token, and no pulse follows it.
- R9: In a ring of devices, at most one device allows writes and at most one allows reads at any time. Words written across device boundaries are read back in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| first_dev | input | 1 | Strap: low on the device that starts with the tokens, high on the others |
| wr_xin | input | 1 | Write token pulse from the previous device |
| rd_xin | input | 1 | Read token pulse from the previous device |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_last | input | 1 | Local write pointer is at the last physical location |
| rd_last | input | 1 | Local read pointer is at the last physical location |
| half_full | input | 1 | Local half-full flag, active high |
| wr_xout_hf | output | 1 | Write token pulse in chain mode, half-full flag in standalone mode |
| rd_xout | output | 1 | Read token pulse to the next device |
| wr_allow | output | 1 | This device may accept a write |
| rd_allow | output | 1 | This device may deliver a read |

## Verification
- **Combinational outputs.** wr_allow and rd_allow follow the token register directly. The shared pin follows half_full with no delay in standalone mode. Both are therefore checked mid-cycle, at the falling edge after the stimulus edge.
- **Release.** With the registered pulse variant, a release shows at the first falling edge after the last-location access: the allow output is low and the pulse output is high.
- **Hand-off.** One full cycle later, the pulse is low again and the next device in the ring allows access. The bench places its checks at exactly those two falling edges.
- **Ring order.** Each word written is logged with the device that owned the write token at that edge. Each word read is taken from the device that owned the read token, and its value is compared with a running sequence number.

// File: rtl/chain_token_pkg.sv
package chain_token_pkg;

   typedef enum logic {
      MODE_SOLO  = 1'b0,
      MODE_CHAIN = 1'b1
   } chain_mode_e;

endpackage

// File: rtl/chain_mode_detect.sv
module chain_mode_detect
   import chain_token_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        first_dev,
   input  logic        x_in,
   output chain_mode_e mode
);

   // Captured only while reset is held; frozen afterwards.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= (first_dev || x_in) ? MODE_CHAIN : MODE_SOLO;
      end
   end

   // R1: mode never changes once reset has been released
   assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode));

endmodule

// File: rtl/chain_token_stage.sv
module chain_token_stage #(
   parameter int OUT_REG = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic first_dev,
   input  logic chain,
   input  logic x_in,
   input  logic en,
   input  logic last,
   output logic allow,
   output logic x_out
);

   localparam bit PULSE_IS_REG = (OUT_REG == 1);

   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_out_reg
      $error("chain_token_stage: OUT_REG must be 0 or 1");
   end

   logic own;
   logic access;
   logic release_now;

   assign allow       = chain ? own : 1'b1;
   assign access      = en && allow;
   assign release_now = chain && access && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own <= !first_dev;
      end else if (release_now) begin
         own <= 1'b0;
      end else if (chain && x_in) begin
         own <= 1'b1;
      end
   end

   if (PULSE_IS_REG) begin : g_pulse_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= release_now;
      end
      assign x_out = pulse_q;
   end else begin : g_pulse_comb
      assign x_out = release_now;
   end

   // R4: token owner right after reset is decided by the strap
   assert_reset_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (own == !first_dev));

   // R5/R6: a last-location access drops the token
   assert_release_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chain && en && own && last) |=> !own);

   // R5/R6: the hand-off pulse lasts a single cycle
   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      x_out |=> !x_out);

   // R7: an incoming pulse grants the token
   assert_grant_on_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chain && x_in && !(en && own && last)) |=> own);

   // R2: standalone devices never emit a hand-off pulse
   assert_solo_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !chain |-> !x_out);

endmodule

// File: rtl/chain_token_ctrl.sv
module chain_token_ctrl
   import chain_token_pkg::*;
#(
   parameter int OUT_REG = 1
) (
   input  logic wr_clk,
   input  logic rd_clk,
   input  logic rst_n,
   input  logic first_dev,
   input  logic wr_xin,
   input  logic rd_xin,
   input  logic wr_en,
   input  logic rd_en,
   input  logic wr_last,
   input  logic rd_last,
   input  logic half_full,
   output logic wr_xout_hf,
   output logic rd_xout,
   output logic wr_allow,
   output logic rd_allow
);

   chain_mode_e mode_w;
   chain_mode_e mode_r;
   logic        chain_w;
   logic        chain_r;
   logic        w_pulse;
   logic        r_pulse;

   chain_mode_detect u_mode_w (
      .clk       (wr_clk),
      .rst_n     (rst_n),
      .first_dev (first_dev),
      .x_in      (wr_xin),
      .mode      (mode_w)
   );

   chain_mode_detect u_mode_r (
      .clk       (rd_clk),
      .rst_n     (rd_rst_n_unused_guard(rst_n)),
      .first_dev (first_dev),
      .x_in      (rd_xin),
      .mode      (mode_r)
   );

   function automatic logic rd_rst_n_unused_guard(input logic r);
      return r;
   endfunction

   assign chain_w = (mode_w == MODE_CHAIN);
   assign chain_r = (mode_r == MODE_CHAIN);

   chain_token_stage #(.OUT_REG(OUT_REG)) u_wr_token (
      .clk       (wr_clk),
      .rst_n     (rst_n),
      .first_dev (first_dev),
      .chain     (chain_w),
      .x_in      (wr_xin),
      .en        (wr_en),
      .last      (wr_last),
      .allow     (wr_allow),
      .x_out     (w_pulse)
   );

   chain_token_stage #(.OUT_REG(OUT_REG)) u_rd_token (
      .clk       (rd_clk),
      .rst_n     (rst_n),
      .first_dev (first_dev),
      .chain     (chain_r),
      .x_in      (rd_xin),
      .en        (rd_en),
      .last      (rd_last),
      .allow     (rd_allow),
      .x_out     (r_pulse)
   );

   // During reset every strap-high device signals its presence downstream.
   assign wr_xout_hf = !rst_n ? first_dev : (chain_w ? w_pulse : half_full);
   assign rd_xout    = !rst_n ? first_dev : r_pulse;

endmodule

// File: tb/test_chain_token_ctrl.sv
module test_chain_token_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NDEV       = 3;
   localparam int DEPTH      = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;

   task automatic check(input bit ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #(CLK_PERIOD/2);
   endtask

   // ---------------- ring of three devices ----------------
   logic            wr_en = 1'b0;
   logic            rd_en = 1'b0;
   logic [NDEV-1:0] wx, rx, wa, ra, wl, rl;
   int              wptr [NDEV];
   int              rptr [NDEV];
   logic [17:0]     mem  [NDEV][DEPTH];

   for (genvar k = 0; k < NDEV; k++) begin : g_dev
      assign wl[k] = (wptr[k] == DEPTH-1);
      assign rl[k] = (rptr[k] == DEPTH-1);
      chain_token_ctrl i_chain_token_ctrl (
         .wr_clk     (clk),
         .rd_clk     (clk),
         .rst_n      (rst_n),
         .first_dev  (k != 0),
         .wr_xin     (wx[(k+NDEV-1)%NDEV]),
         .rd_xin     (rx[(k+NDEV-1)%NDEV]),
         .wr_en      (wr_en),
         .rd_en      (rd_en),
         .wr_last    (wl[k]),
         .rd_last    (rl[k]),
         .half_full  (1'b1),
         .wr_xout_hf (wx[k]),
         .rd_xout    (rx[k]),
         .wr_allow   (wa[k]),
         .rd_allow   (ra[k])
      );
   end

   // ---------------- standalone device ----------------
   logic s_hf = 1'b1, s_wen = 1'b0, s_wlast = 1'b0, s_ren = 1'b0, s_rlast = 1'b0;
   logic s_pin, s_rx, s_wa, s_ra;

   chain_token_ctrl i_chain_token_ctrl_solo (
      .wr_clk     (clk),
      .rd_clk     (clk),
      .rst_n      (rst_n),
      .first_dev  (1'b0),
      .wr_xin     (1'b0),
      .rd_xin     (1'b0),
      .wr_en      (s_wen),
      .rd_en      (s_ren),
      .wr_last    (s_wlast),
      .rd_last    (s_rlast),
      .half_full  (s_hf),
      .wr_xout_hf (s_pin),
      .rd_xout    (s_rx),
      .wr_allow   (s_wa),
      .rd_allow   (s_ra)
   );

   // {half_full, wr_en, wr_last, rd_en, rd_last, expected shared pin}
   localparam logic [5:0] VEC [8] = '{
      6'b0_0_0_0_0_0, 6'b1_0_0_0_0_1, 6'b1_1_1_0_0_1, 6'b0_1_1_1_1_0,
      6'b1_1_1_1_1_1, 6'b0_0_1_0_1_0, 6'b1_1_0_1_0_1, 6'b0_1_1_1_1_0
   };

   int next_wr = 0;
   int next_rd = 0;

   function automatic int owner(input logic [NDEV-1:0] v);
      for (int i = 0; i < NDEV; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic write_word();
      int  k;
      bit  was_last;
      while (wa == '0) step();
      check($countones(wa) <= 1, "R9 single write owner", int'(wa), 1);
      k        = owner(wa);
      was_last = wl[k];
      wr_en    = 1'b1;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      mem[k][wptr[k]] = 18'(next_wr);
      next_wr++;
      wptr[k] = (wptr[k] + 1) % DEPTH;
      #(CLK_PERIOD/2 - 1);
      if (was_last) begin
         check(wx[k] == 1'b1 && wa[k] == 1'b0, "R5 write release", {30'd0, wx[k], wa[k]}, 2);
         step();
         check(wx[k] == 1'b0 && wa[(k+1)%NDEV] == 1'b1, "R7 write grant",
               {30'd0, wx[k], wa[(k+1)%NDEV]}, 1);
      end else begin
         check(wa[k] == 1'b1 && wx[k] == 1'b0, "R8 write keeps token", {30'd0, wa[k], wx[k]}, 2);
      end
   endtask

   task automatic read_word();
      int  k;
      bit  was_last;
      while (ra == '0) step();
      check($countones(ra) <= 1, "R9 single read owner", int'(ra), 1);
      k        = owner(ra);
      was_last = rl[k];
      rd_en    = 1'b1;
      @(posedge clk);
      #1;
      rd_en = 1'b0;
      check(int'(mem[k][rptr[k]]) == next_rd, "R9 read order", int'(mem[k][rptr[k]]), next_rd);
      next_rd++;
      rptr[k] = (rptr[k] + 1) % DEPTH;
      #(CLK_PERIOD/2 - 1);
      if (was_last) begin
         check(rx[k] == 1'b1 && ra[k] == 1'b0, "R6 read release", {30'd0, rx[k], ra[k]}, 2);
         step();
         check(rx[k] == 1'b0 && ra[(k+1)%NDEV] == 1'b1, "R7 read grant",
               {30'd0, rx[k], ra[(k+1)%NDEV]}, 1);
      end else begin
         check(ra[k] == 1'b1 && rx[k] == 1'b0, "R8 read keeps token", {30'd0, ra[k], rx[k]}, 2);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < NDEV; i++) begin
         wptr[i] = 0;
         rptr[i] = 0;
      end
      #(CLK_PERIOD/2);
      step();
      step();
      // R3: presence levels during reset
      check(wx == 3'b110, "R3 write presence", int'(wx), 6);
      check(rx == 3'b110, "R3 read presence", int'(rx), 6);
      check(s_pin == 1'b0 && s_rx == 1'b0, "R3 solo pins in reset", {30'd0, s_pin, s_rx}, 0);
      rst_n = 1'b1;
      step();
      // R4: initial owners
      check(wa == 3'b001, "R4 write owner", int'(wa), 1);
      check(ra == 3'b001, "R4 read owner", int'(ra), 1);
      // R1: ring devices in chain mode ignore half_full; solo device shows it
      check(wx == 3'b000, "R1 chain pin not half-full", int'(wx), 0);
      check(s_pin == 1'b1, "R1 solo pin shows half-full", int'(s_pin), 1);

      // R2: standalone table walk
      foreach (VEC[i]) begin
         {s_hf, s_wen, s_wlast, s_ren, s_rlast} = VEC[i][5:1];
         step();
         check(s_pin == VEC[i][0], "R2 solo shared pin", int'(s_pin), int'(VEC[i][0]));
         check(s_wa && s_ra && !s_rx, "R2 solo gates open", {29'd0, s_wa, s_ra, s_rx}, 6);
      end
      s_wen = 1'b0;
      s_ren = 1'b0;

      // R9: data across device boundaries, wrapping the ring
      for (int n = 0; n < 10; n++) write_word();
      for (int n = 0; n < 10; n++) read_word();
      for (int n = 0; n < 10; n++) write_word();
      for (int n = 0; n < 10; n++) read_word();
      check(next_rd == 20, "R9 words read", next_rd, 20);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule